// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a 16-bit rate word into a stream of single-cycle enable pulses for serial bit timing. A phase accumulator takes in the rate word on every enabled clock. Each time the phase crosses a whole turn, one baud tick is issued. The average tick rate is the rate word times the clock frequency divided by 2^20. Because the result is a fixed-point fraction and not an integer divider, a fine rate can be set from any system clock. Each tick lands on the nearest clock edge, so consecutive spacings never differ by more than one cycle.

The phase is split into two parts. The low part carries the fraction; its carry gives an oversampled tick at sixteen times the baud rate. The high part counts those carries, and its wrap is the baud tick. A receiver can use the fast tick to find the middle of a bit, and a transmitter uses the slow one. Dropping the enable clears the phase, so the next character starts from a known phase. A new rate word is used from the next clock on and leaves the current phase untouched.

Top module: `baud_nco_gen`

## Requirements
- R1: While reset is asserted, both tick outputs are low, and the phase restarts from zero once reset is released.
- R2: With enable high, the total phase advances by the rate word on every rising edge. The baud tick is high in the cycle after an edge whose add makes the total cross a multiple of 2^20, so K enabled cycles from zero phase give floor(K*N/2^20) baud ticks.
- R3: The oversampled tick is high in the cycle after an edge whose add makes the total cross a multiple of 2^16, which is 16 times the baud rate.
- R4: Every cycle with a baud tick also has an oversampled tick.
- R5: A rate word of zero produces no ticks of either kind.
- R6: An edge with enable low clears the phase and gives no ticks in the following cycle. Counting starts again from zero phase when enable returns.
- R7: A change of the rate word applies to the add at the next edge, and the accumulated phase is kept.
- R8: With the rate word and enable held constant, any two consecutive baud-tick spacings differ by at most one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the accumulator; low clears the phase |
| nco_val | input | 16 | Rate word added to the phase each clock |
| baud_tick | output | 1 | One pulse per bit time |
| os_tick | output | 1 | One pulse per sixteenth of a bit time |

## Verification
On every cycle, the assertions check the following: the fast tick follows each low-part carry, the baud tick falls on a fast tick, a zero rate word or a low enable silences the outputs, and the spacing between ticks stays within one clock of the previous spacing. Only the bench can show that the tick counts over long windows match the fixed-point rate. It also checks that a restart after enable begins at zero phase and that a change of rate word keeps the phase already accumulated. It does this by keeping its own running total and comparing both outputs to it cycle by cycle.

// File: rtl/baud_nco_pkg.sv
package baud_nco_pkg;
  localparam int unsigned NCO_W_DEF   = 16;
  localparam int unsigned ACC_W_DEF   = 20;
  localparam int unsigned OS_LOG2_DEF = 4;
endpackage

// File: rtl/baud_nco_phase.sv
module baud_nco_phase #(
  parameter int unsigned NCO_W = baud_nco_pkg::NCO_W_DEF,
  parameter int unsigned LOW_W = baud_nco_pkg::ACC_W_DEF - baud_nco_pkg::OS_LOG2_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [NCO_W-1:0] inc,
  output logic             wrap
);
  localparam int unsigned SUM_W = LOW_W + 1;

  logic [LOW_W-1:0] acc_q;
  logic [SUM_W-1:0] sum;

  function automatic logic [SUM_W-1:0] phase_add(input logic [LOW_W-1:0] a,
                                                  input logic [NCO_W-1:0] b);
    return {1'b0, a} + SUM_W'(b);
  endfunction

  assign sum  = phase_add(acc_q, inc);
  assign wrap = enable & sum[LOW_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (!enable) acc_q <= '0;
    else              acc_q <= sum[LOW_W-1:0];
  end
endmodule

// File: rtl/baud_nco_div.sv
module baud_nco_div #(
  parameter int unsigned CNT_W = baud_nco_pkg::OS_LOG2_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic step,
  output logic wrap
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap = enable & step & (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!enable) cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/baud_nco_gen.sv
module baud_nco_gen #(
  parameter int unsigned NCO_W   = baud_nco_pkg::NCO_W_DEF,
  parameter int unsigned ACC_W   = baud_nco_pkg::ACC_W_DEF,
  parameter int unsigned OS_LOG2 = baud_nco_pkg::OS_LOG2_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [NCO_W-1:0] nco_val,
  output logic             baud_tick,
  output logic             os_tick
);
  localparam int unsigned LOW_W = ACC_W - OS_LOG2;

  logic os_wrap;
  logic baud_wrap;
  logic os_tick_q;
  logic baud_tick_q;

  baud_nco_phase #(.NCO_W(NCO_W), .LOW_W(LOW_W)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .inc    (nco_val),
    .wrap   (os_wrap)
  );

  generate
    if (OS_LOG2 > 0) begin : g_os
      baud_nco_div #(.CNT_W(OS_LOG2)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .step   (os_wrap),
        .wrap   (baud_wrap)
      );
    end else begin : g_no_os
      assign baud_wrap = os_wrap;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_tick_q   <= 1'b0;
      baud_tick_q <= 1'b0;
    end else begin
      os_tick_q   <= os_wrap;
      baud_tick_q <= baud_wrap;
    end
  end

  assign os_tick   = os_tick_q;
  assign baud_tick = baud_tick_q;
endmodule

// File: rtl/baud_nco_gen_chk.sv
module baud_nco_gen_chk #(
  parameter int unsigned NCO_W = baud_nco_pkg::NCO_W_DEF,
  parameter int unsigned ACC_W = baud_nco_pkg::ACC_W_DEF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [NCO_W-1:0] nco_val,
  input logic             os_wrap,
  input logic             os_tick,
  input logic             baud_tick
);
  localparam int unsigned GAP_W = ACC_W + 1;

  logic [GAP_W-1:0] gap_q, last_q;
  logic [1:0]       seen_q;
  logic [NCO_W-1:0] nco_prev_q;
  logic             disturb;

  assign disturb = !enable || (nco_val != nco_prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0; last_q <= '0; seen_q <= '0; nco_prev_q <= '0;
    end else begin
      nco_prev_q <= nco_val;
      if (disturb) begin
        gap_q <= '0; seen_q <= '0;
      end else if (baud_tick) begin
        last_q <= gap_q;
        gap_q  <= GAP_W'(1);
        if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
      end else if (!(&gap_q)) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      AST_RESET_QUIET: assert (!os_tick && !baud_tick); // R1
    end
  end

  AST_WRAP_TO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    os_wrap |=> os_tick); // R3

  AST_BAUD_IN_OS: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> os_tick); // R4

  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && nco_val == '0) |=> (!os_tick && !baud_tick)); // R5

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!os_tick && !baud_tick)); // R6

  AST_GAP_JITTER: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && seen_q == 2'd2) |-> ((gap_q + 1'b1 >= last_q) && (gap_q <= last_q + 1'b1))); // R8
endmodule

bind baud_nco_gen baud_nco_gen_chk #(.NCO_W(NCO_W), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .nco_val   (nco_val),
  .os_wrap   (os_wrap),
  .os_tick   (os_tick),
  .baud_tick (baud_tick)
);

// File: tb/baud_nco_gen_test.sv
`timescale 1ns/1ps
module baud_nco_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] nco = 16'd0;
  logic        baud_tick, os_tick;

  int unsigned errors = 0;
  int unsigned checks = 0;
  int unsigned n_os = 0, n_baud = 0;
  logic [63:0] total = 64'd0;

  always #4 clk = ~clk;

  baud_nco_gen uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (en),
    .nco_val   (nco),
    .baud_tick (baud_tick),
    .os_tick   (os_tick)
  );

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One clock: the bench keeps a running total of the phase and predicts ticks
  task automatic step(input string tag);
    logic [63:0] prev;
    bit eo, eb;
    @(posedge clk);
    prev = total;
    if (!rst_n || !en) total = 64'd0;
    else               total = total + 64'(nco);
    eo = rst_n && en && ((total >> 16) != (prev >> 16));
    eb = rst_n && en && ((total >> 20) != (prev >> 20));
    @(negedge clk);
    check(tag, "os_tick", os_tick, eo);
    check(tag, "baud_tick", baud_tick, eb);
    if (baud_tick && !os_tick) check("R4", "os with baud", 0, 1);
    n_os   += os_tick;
    n_baud += baud_tick;
  endtask

  task automatic restart();
    en = 1'b0;
    step("R6");
    en = 1'b1;
    n_os = 0; n_baud = 0;
  endtask

  task automatic t_reset();
    en = 1'b1; nco = 16'hFFFF;
    for (int i = 0; i < 5; i++) step("R1");
    check("R1", "os in reset", os_tick, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 40; i++) step("R1");
  endtask

  task automatic t_rate(input logic [15:0] n, input int k);
    nco = n;
    restart();
    for (int i = 0; i < k; i++) step("R2");
    check("R2", "baud count", n_baud, (longint'(k) * n) >> 20);
    check("R3", "os count", n_os, (longint'(k) * n) >> 16);
  endtask

  task automatic t_zero();
    nco = 16'd0;
    restart();
    for (int i = 0; i < 300; i++) step("R5");
    check("R5", "ticks with zero word", n_os + n_baud, 0);
  endtask

  task automatic t_enable();
    nco = 16'hC000;
    restart();
    for (int i = 0; i < 37; i++) step("R6");
    en = 1'b0;
    n_os = 0; n_baud = 0;
    for (int i = 0; i < 6; i++) step("R6");
    check("R6", "ticks while off", n_os + n_baud, 0);
    en = 1'b1;
    for (int i = 0; i < 60; i++) step("R6");
  endtask

  task automatic t_change();
    nco = 16'h2345;
    restart();
    for (int i = 0; i < 150; i++) step("R7");
    nco = 16'hE001;
    for (int i = 0; i < 150; i++) step("R7");
    nco = 16'h0101;
    for (int i = 0; i < 600; i++) step("R7");
  endtask

  task automatic t_spacing(input logic [15:0] n);
    int last, mn, mx, seen;
    last = 0; mn = 1 << 30; mx = 0; seen = 0;
    nco = n;
    restart();
    for (int i = 1; i <= 3000; i++) begin
      step("R8");
      if (baud_tick) begin
        if (seen > 0) begin
          if (i - last < mn) mn = i - last;
          if (i - last > mx) mx = i - last;
        end
        seen++;
        last = i;
      end
    end
    check("R8", "spacing spread", ((mx - mn) <= 1) ? 1 : 0, 1);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_rate(16'h3000, 1000);
    t_rate(16'hFFFF, 700);
    t_rate(16'h0ABC, 2000);
    t_zero();
    t_enable();
    t_change();
    t_spacing(16'h7531);
    t_spacing(16'hFFFF);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule